// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This engine drives the write side of an external serial NOR flash through a separate command sequencer. It accepts one of four requests: program a byte range, erase one 64 KB block, erase the whole device, or bring the device up. It then emits the required list of flash commands one at a time. Each command is announced with a one-cycle strobe. Its fields stay steady until the sequencer reports completion.

A program request gives a start address, a length and an implicit byte source. The engine cuts that range wherever it crosses a 256-byte page. This is needed because the flash wraps to the page start inside a single program command. Every program or erase command gets a write-enable ahead of it and a status busy poll after it. The whole operation is framed the same way each time. First it leaves the flash's continuous-read state, and at the end it hands the flash back to memory-mapped reading.

The bring-up request runs while the flash still listens on one data line. It sets the quad-enable bit and moves the device to four-line command mode. All later commands are then marked as four-line.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `error` and `cmd_valid` are low and the link is in one-line mode (`cmd_quad` low).
- R2: Request code 3 (bring-up) issues, all with `cmd_quad` low: 0x06, then 0x31 writing one byte 0x02 (bit 1 = quad enable), then a busy poll, then 0x38. Every command after 0x38 completes has `cmd_quad` high.
- R3: A busy poll is command 0x05 reading one byte. It is reissued for as long as bit 0 of the returned byte is 1, and the sequence moves on only once that bit reads 0.
- R4: Request code 0 (program) issues page program 0x02 once per page touched. The first piece holds 256 minus (address mod 256) bytes, limited by the remaining length. Middle pieces hold 256 bytes. Each piece carries its flash address in `cmd_addr`, its size in `cmd_dlen` and its offset into the source in `cmd_src`. No piece crosses a page boundary.
- R5: Every 0x02, 0xD8, 0xC7 and 0x31 command comes directly after a 0x06 and is directly followed by a busy poll.
- R6: Request code 1 (block erase) issues 0xD8 with address `req_block` × 65536. An index at or above the block count (flash size / 65536) is refused.
- R7: Request code 2 (chip erase) issues 0xC7 with no address.
- R8: Program and erase requests start with 0xEB, address 0, mode byte 0x5F and a one-byte read, which exits continuous read. They end with 0xEB, mode byte 0xA0 and `cmd_mapped` high. Bring-up also ends with that second command.
- R9: A program with length 0, or with address + length above the flash size, and an out-of-range block erase raise `error` for one cycle. No command is issued and `done` stays low.
- R10: `busy` is high from the cycle after an accepted request until `done`. `done` pulses for one cycle after the final command completes, with `busy` already low.
- R11: A request presented while `busy` is high is ignored.
- R12: `cmd_valid` is a one-cycle strobe. No new strobe appears until `cmd_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request strobe, taken only while idle |
| req_op | input | 2 | 0 program, 1 block erase, 2 chip erase, 3 bring-up |
| req_addr | input | ADDR_W | program start address |
| req_len | input | ADDR_W+1 | program length in bytes |
| req_block | input | ADDR_W-BLOCK_W+1 | block index for erase |
| busy | output | 1 | operation in progress |
| done | output | 1 | one-cycle completion pulse |
| error | output | 1 | one-cycle refusal pulse |
| cmd_valid | output | 1 | start strobe for the current command |
| cmd_op | output | 8 | flash opcode |
| cmd_quad | output | 1 | command uses four lines in every phase |
| cmd_addr_en | output | 1 | address phase present |
| cmd_addr | output | ADDR_W | flash address |
| cmd_alt_en | output | 1 | mode byte present |
| cmd_alt | output | 8 | mode byte |
| cmd_write | output | 1 | data phase runs toward the flash |
| cmd_dlen | output | PAGE_W+1 | data bytes in the command |
| cmd_src | output | ADDR_W+1 | offset of the first data byte in the program source |
| cmd_wbyte | output | 8 | data byte for one-byte register writes |
| cmd_mapped | output | 1 | leave the sequencer in memory-mapped read |
| cmd_done | input | 1 | current command finished |
| cmd_rdata | input | 8 | byte read by the finished command |

## Verification
The bound checker watches several rules on every cycle. It checks the strobe discipline of the command port and the single-cycle `done` and `error` pulses. It also checks that an error never coincides with activity, that no program piece crosses a page, that block-erase addresses are block aligned, and that bring-up register writes stay in one-line mode. Some behaviour can only be seen in the bench scenarios: the exact order of commands, the chunk sizes and source offsets for unaligned ranges, the repeat of status polls while busy reads 1, the change to four-line mode after bring-up, the refusal cases, and the request that is ignored mid-operation. The bench checks these against a command log recorded by a model of the sequencer.

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ADDR_W  = 24,
  parameter int PAGE_W  = 8,
  parameter int BLOCK_W = 16,
  localparam int LEN_W  = ADDR_W + 1,
  localparam int BIDX_W = ADDR_W - BLOCK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [BIDX_W-1:0] req_block,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              cmd_valid,
  output logic [7:0]        cmd_op,
  output logic              cmd_quad,
  output logic              cmd_addr_en,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_alt_en,
  output logic [7:0]        cmd_alt,
  output logic              cmd_write,
  output logic [PAGE_W:0]   cmd_dlen,
  output logic [LEN_W-1:0]  cmd_src,
  output logic [7:0]        cmd_wbyte,
  output logic              cmd_mapped,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_rdata
);
  localparam logic [PAGE_W:0]   PAGE  = {1'b1, {PAGE_W{1'b0}}};
  localparam logic [ADDR_W+1:0] FLASH = {2'b01, {ADDR_W{1'b0}}};
  localparam logic [BIDX_W-1:0] NBLK  = {1'b1, {(BIDX_W-1){1'b0}}};

  localparam logic [1:0] K_PROG = 2'd0, K_BLK = 2'd1, K_CHIP = 2'd2, K_INIT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_EXIT, S_WREN, S_OP, S_POLL, S_QPI, S_MAP} state_t;

  state_t            state;
  logic [1:0]        kind;
  logic              issued, qmode, done_r, err_r;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain, src;

  logic [PAGE_W:0] page_room, chunk;
  logic            bad_prog, bad_blk, step;

  assign page_room = PAGE - {1'b0, cur_addr[PAGE_W-1:0]};
  assign chunk     = (remain < LEN_W'(page_room)) ? remain[PAGE_W:0] : page_room;
  assign bad_prog  = (req_len == '0) ||
                     (({2'b00, req_addr} + {1'b0, req_len}) > FLASH);
  assign bad_blk   = req_block >= NBLK;
  assign step      = issued && cmd_done;

  assign busy      = state != S_IDLE;
  assign cmd_valid = busy && !issued;
  assign done      = done_r;
  assign error     = err_r;
  assign cmd_quad  = qmode;

  always_comb begin
    cmd_op      = 8'h00;
    cmd_addr_en = 1'b0;
    cmd_addr    = '0;
    cmd_alt_en  = 1'b0;
    cmd_alt     = 8'h00;
    cmd_write   = 1'b0;
    cmd_dlen    = '0;
    cmd_src     = '0;
    cmd_wbyte   = 8'h00;
    cmd_mapped  = 1'b0;
    case (state)
      S_EXIT: begin
        cmd_op      = 8'hEB;
        cmd_addr_en = 1'b1;
        cmd_alt_en  = 1'b1;
        cmd_alt     = 8'h5F;
        cmd_dlen    = (PAGE_W+1)'(1);
      end
      S_WREN: cmd_op = 8'h06;
      S_OP: begin
        case (kind)
          K_PROG: begin
            cmd_op      = 8'h02;
            cmd_addr_en = 1'b1;
            cmd_addr    = cur_addr;
            cmd_write   = 1'b1;
            cmd_dlen    = chunk;
            cmd_src     = src;
          end
          K_BLK: begin
            cmd_op      = 8'hD8;
            cmd_addr_en = 1'b1;
            cmd_addr    = cur_addr;
          end
          K_CHIP: cmd_op = 8'hC7;
          default: begin
            cmd_op    = 8'h31;
            cmd_write = 1'b1;
            cmd_dlen  = (PAGE_W+1)'(1);
            cmd_wbyte = 8'h02;
          end
        endcase
      end
      S_POLL: begin
        cmd_op   = 8'h05;
        cmd_dlen = (PAGE_W+1)'(1);
      end
      S_QPI: cmd_op = 8'h38;
      S_MAP: begin
        cmd_op      = 8'hEB;
        cmd_addr_en = 1'b1;
        cmd_alt_en  = 1'b1;
        cmd_alt     = 8'hA0;
        cmd_mapped  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= K_PROG;
      issued   <= 1'b0;
      qmode    <= 1'b0;
      done_r   <= 1'b0;
      err_r    <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      src      <= '0;
    end else begin
      done_r <= 1'b0;
      err_r  <= 1'b0;
      if (cmd_valid)  issued <= 1'b1;
      else if (step)  issued <= 1'b0;

      case (state)
        S_IDLE: if (req_valid) begin
          kind <= req_op;
          case (req_op)
            K_PROG: if (bad_prog) err_r <= 1'b1;
                    else begin
                      cur_addr <= req_addr;
                      remain   <= req_len;
                      src      <= '0;
                      state    <= S_EXIT;
                    end
            K_BLK:  if (bad_blk) err_r <= 1'b1;
                    else begin
                      cur_addr <= ADDR_W'({req_block, {BLOCK_W{1'b0}}});
                      state    <= S_EXIT;
                    end
            K_CHIP: state <= S_EXIT;
            default: state <= S_WREN;
          endcase
        end
        S_EXIT: if (step) state <= S_WREN;
        S_WREN: if (step) state <= S_OP;
        S_OP: if (step) begin
          if (kind == K_PROG) begin
            cur_addr <= cur_addr + ADDR_W'(chunk);
            remain   <= remain - LEN_W'(chunk);
            src      <= src + LEN_W'(chunk);
          end
          state <= S_POLL;
        end
        S_POLL: if (step && !cmd_rdata[0]) begin
          if (kind == K_PROG && remain != '0) state <= S_WREN;
          else if (kind == K_INIT)            state <= S_QPI;
          else                                state <= S_MAP;
        end
        S_QPI: if (step) begin
          qmode <= 1'b1;
          state <= S_MAP;
        end
        S_MAP: if (step) begin
          done_r <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int ADDR_W  = 24,
  parameter int PAGE_W  = 8,
  parameter int BLOCK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              cmd_valid,
  input logic [7:0]        cmd_op,
  input logic              cmd_quad,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [PAGE_W:0]   cmd_dlen,
  input logic              cmd_done
);
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n)         pend <= 1'b0;
    else if (cmd_valid) pend <= 1'b1;
    else if (cmd_done)  pend <= 1'b0;
  end

  assert_strobe_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !pend);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !error);
  assert_error_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !busy && !cmd_valid);
  assert_error_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
  assert_page_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'h02) |->
      (cmd_dlen != '0) &&
      ((PAGE_W+2)'(cmd_addr[PAGE_W-1:0]) + (PAGE_W+2)'(cmd_dlen) <= (PAGE_W+2)'(1 << PAGE_W)));
  assert_block_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 8'hD8) |-> cmd_addr[BLOCK_W-1:0] == '0);
  assert_single_line_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 8'h31 || cmd_op == 8'h38)) |-> !cmd_quad);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLOCK_W(BLOCK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_quad(cmd_quad),
  .cmd_addr(cmd_addr), .cmd_dlen(cmd_dlen), .cmd_done(cmd_done));

// File: tb/flash_prog_seq_test.sv
module flash_prog_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [23:0] req_addr = '0;
  logic [24:0] req_len = '0;
  logic [8:0]  req_block = '0;
  logic        busy, done, error, cmd_valid, cmd_quad, cmd_addr_en, cmd_alt_en, cmd_write, cmd_mapped;
  logic [7:0]  cmd_op, cmd_alt, cmd_wbyte;
  logic [23:0] cmd_addr;
  logic [8:0]  cmd_dlen;
  logic [24:0] cmd_src;
  logic        cmd_done = 1'b0;
  logic [7:0]  cmd_rdata = '0;

  flash_prog_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_block(req_block),
    .busy(busy), .done(done), .error(error), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_quad(cmd_quad), .cmd_addr_en(cmd_addr_en),
    .cmd_addr(cmd_addr), .cmd_alt_en(cmd_alt_en), .cmd_alt(cmd_alt),
    .cmd_write(cmd_write), .cmd_dlen(cmd_dlen), .cmd_src(cmd_src),
    .cmd_wbyte(cmd_wbyte), .cmd_mapped(cmd_mapped), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int lc = 0;
  int pc = 0;
  logic [7:0]  l_op [64];
  logic        l_q  [64];
  logic [23:0] l_a  [64];
  logic [8:0]  l_dl [64];
  logic [24:0] l_s  [64];
  logic [7:0]  l_alt[64];
  logic        l_mp [64];
  logic [7:0]  l_wb [64];

  initial begin
    forever begin
      while (!cmd_valid) @(negedge clk);
      if (lc < 64) begin
        l_op[lc] = cmd_op; l_q[lc] = cmd_quad; l_a[lc] = cmd_addr; l_dl[lc] = cmd_dlen;
        l_s[lc] = cmd_src; l_alt[lc] = cmd_alt; l_mp[lc] = cmd_mapped; l_wb[lc] = cmd_wbyte;
      end
      lc++;
      repeat (2) @(negedge clk);
      if (cmd_op == 8'h05) begin
        cmd_rdata = (pc < 1) ? 8'h01 : 8'h00;
        pc++;
      end else begin
        cmd_rdata = 8'h00;
        pc = 0;
      end
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
    end
  end

  task automatic check(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic chk_cmd(input int i, input string r, input logic [7:0] op, input logic q,
                         input logic [23:0] a, input logic [8:0] dl, input logic [24:0] s,
                         input logic [7:0] alt, input logic mp, input logic [7:0] wb);
    logic [127:0] act, exp;
    act = {l_op[i], l_q[i], l_a[i], l_dl[i], l_s[i], l_alt[i], l_mp[i], l_wb[i]};
    exp = {op, q, a, dl, s, alt, mp, wb};
    check(act == exp, r, act, exp);
  endtask

  task automatic start(input logic [1:0] op, input logic [23:0] a, input logic [24:0] len,
                       input logic [8:0] blk, output logic err_now, output logic busy_now);
    pc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = len; req_block = blk;
    @(negedge clk);
    req_valid = 1'b0;
    err_now = error;
    busy_now = busy;
  endtask

  task automatic wait_done(input string r);
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen && !busy, r, {seen, busy}, 2'b10);
  endtask

  task automatic t_reset;
    check({busy, done, error, cmd_valid, cmd_quad} == 5'b0, "R1",
          {busy, done, error, cmd_valid, cmd_quad}, 5'b0);
  endtask

  task automatic t_init;
    logic e, b;
    int base = lc;
    start(2'd3, '0, '0, '0, e, b);
    wait_done("R10 bring-up done");
    check(lc - base == 6, "R2 bring-up count", lc - base, 6);
    chk_cmd(base+0, "R2 wren", 8'h06, 0, 0, 0, 0, 0, 0, 0);
    chk_cmd(base+1, "R2 sr2 write", 8'h31, 0, 0, 1, 0, 0, 0, 8'h02);
    chk_cmd(base+2, "R3 poll busy", 8'h05, 0, 0, 1, 0, 0, 0, 0);
    chk_cmd(base+3, "R3 poll clear", 8'h05, 0, 0, 1, 0, 0, 0, 0);
    chk_cmd(base+4, "R2 enter quad", 8'h38, 0, 0, 0, 0, 0, 0, 0);
    chk_cmd(base+5, "R8 restore map", 8'hEB, 1, 0, 0, 0, 8'hA0, 1, 0);
  endtask

  task automatic t_prog_unaligned;
    logic e, b;
    int base = lc;
    start(2'd0, 24'h0000F0, 25'd304, '0, e, b);
    check(b && !e, "R10 busy after accept", {b, e}, 2'b10);
    repeat (20) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done("R10 program done");
    check(lc - base == 14, "R11 R4 program count", lc - base, 14);
    chk_cmd(base+0, "R8 exit read", 8'hEB, 1, 0, 1, 0, 8'h5F, 0, 0);
    chk_cmd(base+1, "R5 wren 1", 8'h06, 1, 0, 0, 0, 0, 0, 0);
    chk_cmd(base+2, "R4 head piece", 8'h02, 1, 24'h0000F0, 9'd16, 25'd0, 0, 0, 0);
    chk_cmd(base+3, "R5 poll 1", 8'h05, 1, 0, 1, 0, 0, 0, 0);
    chk_cmd(base+5, "R5 wren 2", 8'h06, 1, 0, 0, 0, 0, 0, 0);
    chk_cmd(base+6, "R4 full piece", 8'h02, 1, 24'h000100, 9'd256, 25'd16, 0, 0, 0);
    chk_cmd(base+10, "R4 tail piece", 8'h02, 1, 24'h000200, 9'd32, 25'd272, 0, 0, 0);
    chk_cmd(base+12, "R3 final poll", 8'h05, 1, 0, 1, 0, 0, 0, 0);
    chk_cmd(base+13, "R8 map after program", 8'hEB, 1, 0, 0, 0, 8'hA0, 1, 0);
  endtask

  task automatic t_prog_aligned;
    logic e, b;
    int base = lc;
    start(2'd0, 24'h000300, 25'd256, '0, e, b);
    wait_done("R10 aligned done");
    check(lc - base == 6, "R4 aligned count", lc - base, 6);
    chk_cmd(base+2, "R4 aligned page", 8'h02, 1, 24'h000300, 9'd256, 25'd0, 0, 0, 0);
    base = lc;
    start(2'd0, 24'hFFFF00, 25'd256, '0, e, b);
    check(!e, "R9 top page accepted", e, 0);
    wait_done("R10 top page done");
    chk_cmd(base+2, "R4 top page", 8'h02, 1, 24'hFFFF00, 9'd256, 25'd0, 0, 0, 0);
  endtask

  task automatic t_refuse(input logic [1:0] op, input logic [23:0] a, input logic [24:0] len,
                          input logic [8:0] blk, input string r);
    logic e, b;
    bit dn = 0;
    int base = lc;
    start(op, a, len, blk, e, b);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done || busy) dn = 1;
    end
    check(e && !b && !dn && lc == base, r, {e, b, dn, 32'(lc - base)}, {3'b100, 32'd0});
  endtask

  task automatic t_block;
    logic e, b;
    int base = lc;
    start(2'd1, '0, '0, 9'd5, e, b);
    wait_done("R10 block done");
    check(lc - base == 6, "R6 block count", lc - base, 6);
    chk_cmd(base+1, "R5 block wren", 8'h06, 1, 0, 0, 0, 0, 0, 0);
    chk_cmd(base+2, "R6 block erase", 8'hD8, 1, 24'h050000, 0, 0, 0, 0, 0);
    chk_cmd(base+4, "R5 block poll", 8'h05, 1, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_chip;
    logic e, b;
    int base = lc;
    start(2'd2, '0, '0, '0, e, b);
    wait_done("R10 chip done");
    check(lc - base == 6, "R7 chip count", lc - base, 6);
    chk_cmd(base+0, "R8 chip exit", 8'hEB, 1, 0, 1, 0, 8'h5F, 0, 0);
    chk_cmd(base+2, "R7 chip erase", 8'hC7, 1, 0, 0, 0, 0, 0, 0);
    chk_cmd(base+5, "R8 chip map", 8'hEB, 1, 0, 0, 0, 8'hA0, 1, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_init();
    t_prog_unaligned();
    t_prog_aligned();
    t_refuse(2'd0, 24'h000010, 25'd0, '0, "R9 zero length");
    t_refuse(2'd0, 24'hFFFFF0, 25'h20, '0, "R9 past end");
    t_block();
    t_refuse(2'd1, '0, '0, 9'd256, "R6 R9 block index");
    t_chip();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule